// File: doc/BRIEF.md
# Sequential Turn-Signal Tail Lamp Controller

This block drives two groups of three tail lamps, one group per side of a vehicle. A held left or right request makes that side's lamps run a cumulative sweep: the inner lamp, then the inner two, then all three, then a dark step, repeating for as long as the request stays high. A hazard request runs both sides together, and one shared step counter keeps the two sides in step.

The lamp outputs are decoded combinationally from the registered mode and step and from the live requests. A sequence therefore lights its first lamp in the same cycle its request is first seen while the controller is idle. The sequence is cut off in the same cycle its request falls.

While a sequence runs, the controller ignores the other requests. Each step lasts one clock cycle. A visible flash rate comes from clocking the block at the step rate.

Top module: `tail_lamp_seq`

## Requirements
- R1: While `rst_n` is low, every lamp output is 0 whatever the requests are, and the first cycle after reset is idle.
- R2: On an active side, the lamp vector (bit 0 = inner lamp A, bit 1 = B, bit 2 = outer lamp C) takes the values 3'b001, 3'b011, 3'b111, 3'b000 in that order. It advances one value per clock cycle and repeats while the initiating request stays high.
- R3: A left sequence drives only `lamp_left`. `lamp_right` stays 3'b000.
- R4: A right sequence drives only `lamp_right`. `lamp_left` stays 3'b000.
- R5: In a hazard sequence, `lamp_left` and `lamp_right` are equal in every cycle.
- R6: When the controller is idle and several requests are high, hazard wins over left, and left wins over right.
- R7: A request that is high in an idle cycle shows step one (3'b001 on its side or sides) in that same cycle.
- R8: In a cycle after its first in which the initiating request is low, the sequence stops. If no other request is high, all lamps are 3'b000 in that cycle and the controller is idle.
- R9: While a sequence runs, the other requests have no effect on either lamp output.
- R10: In the cycle a sequence stops, the requests are checked again under the R6 priority. A request that is high then starts its sequence at step one in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one step per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_left | input | 1 | Left turn request, level sensitive |
| req_right | input | 1 | Right turn request, level sensitive |
| req_hazard | input | 1 | Hazard request, level sensitive |
| lamp_left | output | 3 | Left lamps, bit 0 inner (A) to bit 2 outer (C) |
| lamp_right | output | 3 | Right lamps, bit 0 inner (A) to bit 2 outer (C) |

## Verification
The bench targets the cycle in which a request falls. A design that registered the stop would show one extra step there. A design that did not re-arbitrate would lose a cycle, or start a waiting request part-way through its pattern instead of at the inner lamp. It raises hazard during a left sequence to catch a controller that preempts instead of ignoring. It drives all three requests from idle to expose a wrong priority, and it checks that reset blanks the lamps even with hazard held.

// File: rtl/tlc_pkg.sv
// Shared types for the tail lamp controller.
// Assumes: a two-bit mode code is enough for idle plus three sequence kinds.
package tlc_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_HAZARD = 2'd1,
        MODE_LEFT   = 2'd2,
        MODE_RIGHT  = 2'd3
    } seq_mode_e;
endpackage

// File: rtl/tlc_mode_select.sv
// Picks the mode and step that are in force during the current cycle.
// A running mode continues while its own request is high. Otherwise the
// requests are arbitrated (hazard, then left, then right) and a winner starts
// at step zero in the same cycle. Assumes the requests are synchronous to clk.
module tlc_mode_select
    import tlc_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  logic              rst_n,
    input  logic              req_left,
    input  logic              req_right,
    input  logic              req_hazard,
    input  seq_mode_e         mode_q,
    input  logic [STEP_W-1:0] step_q,
    output seq_mode_e         eff_mode,
    output logic [STEP_W-1:0] eff_step
);
    logic own_req_high;

    // Purpose: tell whether the request that started the running mode is still high.
    always_comb begin
        case (mode_q)
            MODE_HAZARD: own_req_high = req_hazard;
            MODE_LEFT:   own_req_high = req_left;
            MODE_RIGHT:  own_req_high = req_right;
            default:     own_req_high = 1'b0;
        endcase
    end

    // Purpose: continue the running mode, or arbitrate a new one that starts at step zero.
    always_comb begin
        eff_mode = MODE_IDLE;
        eff_step = '0;
        if (!rst_n) begin
            eff_mode = MODE_IDLE;
        end else if (own_req_high) begin
            eff_mode = mode_q;
            eff_step = step_q;
        end else if (req_hazard) begin
            eff_mode = MODE_HAZARD;
        end else if (req_left) begin
            eff_mode = MODE_LEFT;
        end else if (req_right) begin
            eff_mode = MODE_RIGHT;
        end
    end
endmodule

// File: rtl/tlc_step_reg.sv
// Holds the mode and the step for the next cycle. An active step wraps after
// NUM_STEPS values. Assumes eff_step < NUM_STEPS.
module tlc_step_reg
    import tlc_pkg::*;
#(
    parameter int NUM_STEPS = 4,
    parameter int STEP_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_mode_e         eff_mode,
    input  logic [STEP_W-1:0] eff_step,
    output seq_mode_e         mode_q,
    output logic [STEP_W-1:0] step_q
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    // Purpose: advance the step of the mode in force, or fall back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || eff_mode == MODE_IDLE) begin
            mode_q <= MODE_IDLE;
            step_q <= '0;
        end else begin
            mode_q <= eff_mode;
            step_q <= (eff_step == LAST_STEP) ? '0 : eff_step + 1'b1;
        end
    end
endmodule

// File: rtl/tlc_lamp_decode.sv
// Turns the mode and step in force into lamp vectors. Step k < NUM_LAMPS lights
// lamps 0..k on each enabled side; the step after that is dark.
// Assumes lamp index 0 is the inner lamp.
module tlc_lamp_decode
    import tlc_pkg::*;
#(
    parameter int NUM_LAMPS = 3,
    parameter int STEP_W    = 2
) (
    input  seq_mode_e             eff_mode,
    input  logic [STEP_W-1:0]     eff_step,
    output logic [NUM_LAMPS-1:0]  lamp_left,
    output logic [NUM_LAMPS-1:0]  lamp_right
);
    logic left_on;
    logic right_on;

    // Purpose: enable each side from the mode in force.
    always_comb begin
        left_on  = (eff_mode == MODE_LEFT)  || (eff_mode == MODE_HAZARD);
        right_on = (eff_mode == MODE_RIGHT) || (eff_mode == MODE_HAZARD);
    end

    for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lamp
        logic lit;
        // Purpose: lamp i glows from step i up to the last lit step.
        always_comb begin
            lit = (32'(eff_step) >= i) && (32'(eff_step) < NUM_LAMPS);
        end
        assign lamp_left[i]  = left_on && lit;
        assign lamp_right[i] = right_on && lit;
    end
endmodule

// File: rtl/tail_lamp_seq.sv
// Top of the turn-signal tail lamp sequencer. It holds one shared step counter
// for both sides, so a hazard sequence keeps the sides in step. The lamps are
// combinational from the registered state and the live requests: a start and a
// stop take effect in the cycle the request changes.
// Assumes one step per clock cycle and requests synchronous to clk.
module tail_lamp_seq
    import tlc_pkg::*;
#(
    parameter int NUM_LAMPS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_left,
    input  logic                 req_right,
    input  logic                 req_hazard,
    output logic [NUM_LAMPS-1:0] lamp_left,
    output logic [NUM_LAMPS-1:0] lamp_right
);
    localparam int NUM_STEPS = NUM_LAMPS + 1;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam logic [NUM_LAMPS-1:0] ALL_ON = '1;

    seq_mode_e         mode_q;
    seq_mode_e         eff_mode;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] eff_step;

    tlc_mode_select #(.STEP_W(STEP_W)) u_select (
        .rst_n(rst_n), .req_left(req_left), .req_right(req_right),
        .req_hazard(req_hazard), .mode_q(mode_q), .step_q(step_q),
        .eff_mode(eff_mode), .eff_step(eff_step)
    );

    tlc_step_reg #(.NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W)) u_step (
        .clk(clk), .rst_n(rst_n), .eff_mode(eff_mode), .eff_step(eff_step),
        .mode_q(mode_q), .step_q(step_q)
    );

    tlc_lamp_decode #(.NUM_LAMPS(NUM_LAMPS), .STEP_W(STEP_W)) u_decode (
        .eff_mode(eff_mode), .eff_step(eff_step),
        .lamp_left(lamp_left), .lamp_right(lamp_right)
    );

    // R1: reset blanks every lamp.
    assert_reset_dark_R1: assert property (@(posedge clk)
        !rst_n |-> (lamp_left == '0 && lamp_right == '0));

    // R2: a held left sequence grows by one lamp per cycle.
    assert_left_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LEFT && req_left && $past(lamp_left) != '0 && $past(lamp_left) != ALL_ON)
        |-> lamp_left == NUM_LAMPS'(($past(lamp_left) << 1) | 1'b1));

    // R3: a held left sequence leaves the right side dark.
    assert_left_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LEFT && req_left) |-> lamp_right == '0);

    // R5: a held hazard sequence keeps both sides identical.
    assert_hazard_lockstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HAZARD && req_hazard) |-> lamp_left == lamp_right);

    // R7: hazard seen while idle lights the inner lamps at once.
    assert_idle_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && req_hazard)
        |-> (lamp_left == NUM_LAMPS'(1) && lamp_right == NUM_LAMPS'(1)));

    // R8: with every request low, all lamps are dark.
    assert_release_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_left && !req_right && !req_hazard) |-> (lamp_left == '0 && lamp_right == '0));
endmodule

// File: tb/tail_lamp_seq_tb_top.sv
module tail_lamp_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_left = 1'b0;
    logic req_right = 1'b0;
    logic req_hazard = 1'b0;
    logic [2:0] lamp_left;
    logic [2:0] lamp_right;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state: 0 idle, 1 hazard, 2 left, 3 right.
    int m_mode = 0;
    int m_step = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tail_lamp_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_left(req_left), .req_right(req_right),
        .req_hazard(req_hazard), .lamp_left(lamp_left), .lamp_right(lamp_right)
    );

    function automatic logic [2:0] pattern(input int s);
        return (s < 3) ? 3'((1 << (s + 1)) - 1) : 3'b000;
    endfunction

    function automatic bit req_of(input int m, input logic l, input logic r, input logic h);
        case (m)
            1: return h;
            2: return l;
            3: return r;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [2:0] el, input logic [2:0] er);
        n_checks++;
        if (lamp_left !== el || lamp_right !== er) begin
            n_fail++;
            $display("FAIL %s: lamp_left=%b lamp_right=%b expected %b %b at %0t",
                     tag, lamp_left, lamp_right, el, er, $time);
        end
    endtask

    // Drive one cycle, check the lamps against the model, then advance the model.
    task automatic step_cycle(input logic l, input logic r, input logic h);
        bit cont;
        int em;
        int es;
        string tag;
        logic [2:0] el;
        logic [2:0] er;
        @(negedge clk);
        req_left = l; req_right = r; req_hazard = h;
        #1;
        cont = (m_mode != 0) && req_of(m_mode, l, r, h);
        if (cont) begin
            em = m_mode; es = m_step;
            if ((em != 1 && h) || (em != 2 && l) || (em != 3 && r)) tag = "R9";
            else if (em == 1) tag = "R5";
            else if (em == 2) tag = "R3";
            else tag = "R4";
            if (es != 0 && tag != "R9" && (es % 2) == 0) tag = "R2";
        end else begin
            es = 0;
            if (h) em = 1; else if (l) em = 2; else if (r) em = 3; else em = 0;
            if (m_mode != 0) tag = (em != 0) ? "R10" : "R8";
            else if (int'(h) + int'(l) + int'(r) > 1) tag = "R6";
            else tag = "R7";
        end
        el = (em == 1 || em == 2) ? pattern(es) : 3'b000;
        er = (em == 1 || em == 3) ? pattern(es) : 3'b000;
        check(tag, el, er);
        if (em == 0) begin
            m_mode = 0; m_step = 0;
        end else begin
            m_mode = em; m_step = (es + 1) % 4;
        end
    endtask

    initial begin
        int seed;
        logic l, r, h;
        seed = $urandom(32'd1234);
        // R1: lamps dark in reset even with hazard held.
        req_hazard = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check("R1", 3'b000, 3'b000);
        end
        @(negedge clk);
        req_hazard = 1'b0; rst_n = 1'b1;
        m_mode = 0; m_step = 0;
        // R2/R3: left held through two full patterns.
        for (int i = 0; i < 9; i++) step_cycle(1, 0, 0);
        // R8: left drops, nothing else requested.
        step_cycle(0, 0, 0);
        // R4: right held.
        for (int i = 0; i < 5; i++) step_cycle(0, 1, 0);
        step_cycle(0, 0, 0);
        // R6: all three requests from idle; hazard wins.
        for (int i = 0; i < 3; i++) step_cycle(1, 1, 1);
        step_cycle(0, 0, 0);
        // R6: left and right from idle; left wins.
        for (int i = 0; i < 2; i++) step_cycle(1, 1, 0);
        step_cycle(0, 0, 0);
        // R9 then R10: hazard rises during left, left drops, hazard starts at step one.
        step_cycle(1, 0, 0);
        step_cycle(1, 0, 1);
        step_cycle(1, 0, 1);
        step_cycle(0, 0, 1);
        step_cycle(0, 0, 1);
        step_cycle(0, 0, 0);
        // Constrained random: requests mostly held, sometimes toggled.
        l = 0; r = 0; h = 0;
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                l = ($urandom_range(0, 9) < 4);
                r = ($urandom_range(0, 9) < 4);
                h = ($urandom_range(0, 9) < 2);
            end
            step_cycle(l, r, h);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule